// File: doc/BRIEF.md
# External Device Bus Controller

This block turns single-word read and write requests from an on-chip master into strobed cycles on an external bus. The bus connects boot ROM, flash, SRAM and memory-mapped peripherals. The top bits of the request's word address pick one of six banks. Each bank has its own configuration, fixed by parameters:

- port width of 8, 16 or 32 bits;
- a wait-state count that sets the minimum strobe width;
- a write-protect bit;
- a choice of how the external handshake input ends a cycle. It either holds the cycle open while low (wait mode) or closes it when low (acknowledge mode).

A 32-bit request to a narrower port is split into sequential beats at incrementing byte addresses. Read bytes are packed into the word in little-endian order.

The controller also drives the controls for external data transceivers. An active-low direction line is low for every read. One active-low output enable is used for device reads and a second one for SDRAM reads. An SDRAM controller elsewhere signals its reads on an input only so that this block can drive the direction line and the second enable; SDRAM timing is not handled here.

The internal side uses a level request held until a one-cycle acknowledge. The acknowledge carries the read word and an error flag. The error flag is raised for writes to a protected bank and for accesses to an unmapped bank index. In both cases no external cycle is run.

Top module: `xbus_ctrl`

## Requirements
- R1: Word-address bits [26:24] select bank k (0 to 5). During that access's strobe, only `ext_cs_n_o[k]` is low; at most one select is ever low, and a select is low only while a read or write strobe is low.
- R2: A bank with width code 0 (8-bit) runs 4 beats at byte addresses base+0..3. Code 1 (16-bit) runs 2 beats at base+0 and base+2. Code 2 (32-bit) runs 1 beat at base. Here base is the request word address times 4, within the bank.
- R3: A write beat places its data on the low lanes of `ext_wdata_o` and drives the upper unused lanes to zero. An 8-bit beat k carries request byte k, and a 16-bit beat k carries half-word k. `ext_be_n_o` is the inverse of the matching request byte enables, the upper unused lanes read 1, and read beats drive `ext_be_n_o` all zero.
- R4: Read data is assembled little-endian. On an 8-bit port, byte k of `rdata_o` comes from bits [7:0] of beat k. On a 16-bit port, half-word k comes from bits [15:0] of beat k. On a 32-bit port, the word is the single beat.
- R5: Each strobe stays low for at least W+1 cycles, where W is the bank's wait-state count. The handshake input is first sampled in the last of those cycles.
- R6: In wait mode (bank's mode bit 0), the strobe stays low as long as `ext_hs_n_i` is low at a sampling point. The beat ends at the first sampling point where it is high.
- R7: In acknowledge mode (mode bit 1), the strobe stays low while `ext_hs_n_i` is high. The beat ends at the first sampling point where it is low.
- R8: After every beat, the strobe and chip select go high for exactly one cycle. The bus address is stable while a strobe is low.
- R9: `ext_dir_n_o` is low during every device read strobe and while `sdram_rd_i` is high. It is high during write strobes.
- R10: `ext_oe_n_o[0]` is low only during device read strobes. `ext_oe_n_o[1]` is low exactly while `sdram_rd_i` is high.
- R11: A write to a write-protected bank (bank 3 by default) runs no strobe. It is acknowledged on the first edge after acceptance, with `err_o` high. Reads of that bank run normally.
- R12: A request whose bank index is 6 or 7 runs no strobe and asserts no select. It is acknowledged on the first edge after acceptance, with `err_o` high.
- R13: `ack_o` is high for a single cycle per request. With N beats, W wait states and per-beat extension D, `ack_o` rises N*(max(W,D)+2) edges after the accepting edge. `rdata_o` is valid while `ack_o` is high, and `err_o` is high only with `ack_o`.
- R14: After reset, all selects, both strobes and both output enables are high, `ext_dir_n_o` is high, and `ack_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Request, held until acknowledged |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_waddr_i | input | 27 | Word address: [26:24] bank, [23:0] word within bank |
| req_wdata_i | input | 32 | Write word |
| req_be_i | input | 4 | Byte enables of the write word |
| ack_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Protected or unmapped access, valid with `ack_o` |
| rdata_o | output | 32 | Assembled read word |
| sdram_rd_i | input | 1 | SDRAM read in progress elsewhere |
| ext_addr_o | output | 26 | External byte address within bank |
| ext_wdata_o | output | 32 | External write data |
| ext_rdata_i | input | 32 | External read data |
| ext_be_n_o | output | 4 | Active-low byte lane enables |
| ext_cs_n_o | output | 6 | Active-low bank selects |
| ext_rd_n_o | output | 1 | Active-low read strobe |
| ext_wr_n_o | output | 1 | Active-low write strobe |
| ext_hs_n_i | input | 1 | Active-low wait or acknowledge input |
| ext_dir_n_o | output | 1 | Transceiver direction, low for reads |
| ext_oe_n_o | output | 2 | Transceiver enables: [0] device read, [1] SDRAM read |

## Verification
Strobes, selects, address, lane data and transceiver controls are decoded from registered state. They therefore change straight after the edge that moves the controller, and the bench's responder samples them at the falling edge. The responder drives the handshake line from the number of strobe cycles it has seen, so each beat lasts max(W,D)+1 strobe cycles plus one gap cycle. The bench counts rising edges from the first edge that sees the request and expects the acknowledge exactly N*(max(W,D)+2)+1 edges in, or 1 edge in for error cases. It samples one nanosecond after each edge and reads the data, error and captured beat log only at that acknowledge.

// File: rtl/xbus_pkg.sv
// Shared types for the external device bus controller.
// Assumes a 32-bit data path split into at most four beats.
package xbus_pkg;

    localparam int XB_WAIT_W = 4;

    // Port width codes of a bank.
    localparam logic [1:0] PW_8  = 2'd0;
    localparam logic [1:0] PW_16 = 2'd1;

    typedef struct packed {
        logic [1:0]           pw;
        logic [XB_WAIT_W-1:0] waits;
        logic                 wp;
        logic                 ackm;
    } bank_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_STRB  = 2'd1,
        ST_RECOV = 2'd2,
        ST_DONE  = 2'd3
    } xb_state_e;

    // Index of the final beat for a port width code.
    function automatic logic [1:0] last_beat(input logic [1:0] pw);
        case (pw)
            PW_8:    return 2'd3;
            PW_16:   return 2'd1;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/xbus_bank_dec.sv
// Bank decoder: maps the bank field of a request to a one-hot select
// and that bank's configuration. Assumes NUM_BANKS <= 2**SEL_W; an
// index beyond the last bank reports no hit.
module xbus_bank_dec
    import xbus_pkg::*;
#(
    parameter int NUM_BANKS = 6,
    parameter int SEL_W     = 3,
    parameter logic [2*NUM_BANKS-1:0]         BANK_PW    = '0,
    parameter logic [XB_WAIT_W*NUM_BANKS-1:0] BANK_WAITS = '0,
    parameter logic [NUM_BANKS-1:0]           BANK_WP    = '0,
    parameter logic [NUM_BANKS-1:0]           BANK_ACK   = '0
) (
    input  logic [SEL_W-1:0]     sel_i,
    output bank_cfg_t            cfg_o,
    output logic                 hit_o,
    output logic [NUM_BANKS-1:0] onehot_o
);

    bank_cfg_t tbl [NUM_BANKS];

    // Per-bank configuration table and select decode.
    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        assign tbl[g] = '{pw:    BANK_PW[2*g +: 2],
                          waits: BANK_WAITS[XB_WAIT_W*g +: XB_WAIT_W],
                          wp:    BANK_WP[g],
                          ackm:  BANK_ACK[g]};
        assign onehot_o[g] = (sel_i == SEL_W'(g));
    end

    // Pick the selected bank's configuration.
    always_comb begin
        hit_o = |onehot_o;
        cfg_o = '0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (onehot_o[i]) cfg_o = tbl[i];
        end
    end

endmodule

// File: rtl/xbus_seq.sv
// Cycle sequencer: accepts a request, runs one strobe per beat with a
// minimum width from the wait count, ends each beat on the handshake
// input, inserts one recovery cycle, then one acknowledge cycle.
// Assumes the requester holds req_i until the acknowledge.
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int WAIT_W = XB_WAIT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              ok_i,
    input  logic [1:0]        last_i,
    input  logic [WAIT_W-1:0] waits_i,
    input  logic              ackm_i,
    input  logic              hs_n_i,
    output xb_state_e         st_o,
    output logic [1:0]        beat_o,
    output logic              beat_end_o
);

    xb_state_e         st;
    logic [WAIT_W-1:0] cnt;
    logic [1:0]        beat;
    logic              end_c;

    // Handshake level that closes a beat in the bank's mode.
    always_comb begin
        end_c      = ackm_i ? ~hs_n_i : hs_n_i;
        beat_end_o = (st == ST_STRB) && (cnt == '0) && end_c;
    end

    // State, wait counter and beat index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ST_IDLE;
            cnt  <= '0;
            beat <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (req_i) begin
                        beat <= '0;
                        cnt  <= waits_i;
                        st   <= ok_i ? ST_STRB : ST_DONE;
                    end
                end
                ST_STRB: begin
                    if (cnt != '0)  cnt <= cnt - 1'b1;
                    else if (end_c) st  <= ST_RECOV;
                end
                ST_RECOV: begin
                    if (beat == last_i) begin
                        st <= ST_DONE;
                    end else begin
                        beat <= beat + 1'b1;
                        cnt  <= waits_i;
                        st   <= ST_STRB;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign st_o   = st;
    assign beat_o = beat;

    // R6: in wait mode a low handshake at the sampling point keeps the strobe.
    p_wait_extend_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_STRB && cnt == '0 && !ackm_i && !hs_n_i) |=> (st == ST_STRB));

    // R7: in acknowledge mode a high handshake at the sampling point keeps the strobe.
    p_ack_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_STRB && cnt == '0 && ackm_i && hs_n_i) |=> (st == ST_STRB));

endmodule

// File: rtl/xbus_rd_pack.sv
// Read assembler: places each read beat's low lanes into the result
// word at the beat's position, little-endian. Assumes a 32-bit word.
module xbus_rd_pack
    import xbus_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_i,
    input  logic [1:0]        pw_i,
    input  logic [1:0]        beat_i,
    input  logic [DATA_W-1:0] bus_i,
    output logic [DATA_W-1:0] word_o
);

    logic [DATA_W-1:0] word;

    // Merge the captured beat into the result word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= '0;
        end else if (cap_i) begin
            case (pw_i)
                PW_8:    word[8*beat_i +: 8]     <= bus_i[7:0];
                PW_16:   word[16*beat_i[0] +: 16] <= bus_i[15:0];
                default: word                    <= bus_i;
            endcase
        end
    end

    assign word_o = word;

    // R4: a full-width beat lands in the word unchanged.
    p_full_beat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_i && pw_i != PW_8 && pw_i != PW_16) |=> (word_o == $past(bus_i)));

endmodule

// File: rtl/xbus_ctrl.sv
// External device bus controller top. Decodes the bank of a request,
// runs one or more strobed beats on the external bus per the bank's
// width, wait count and handshake mode, blocks protected writes, and
// drives transceiver direction and output enables. Assumes word-aligned
// requests and a requester that holds req_i until ack_o.
module xbus_ctrl
    import xbus_pkg::*;
#(
    parameter int NUM_BANKS = 6,
    parameter int BANK_AW   = 26,
    parameter int DATA_W    = 32,
    parameter logic [2*NUM_BANKS-1:0]         BANK_PW    = 12'b01_00_10_10_01_00,
    parameter logic [XB_WAIT_W*NUM_BANKS-1:0] BANK_WAITS = 24'h2_1_2_0_1_3,
    parameter logic [NUM_BANKS-1:0]           BANK_WP    = 6'b001000,
    parameter logic [NUM_BANKS-1:0]           BANK_ACK   = 6'b110000
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            req_i,
    input  logic                            req_we_i,
    input  logic [BANK_AW+$clog2(NUM_BANKS)-3:0] req_waddr_i,
    input  logic [DATA_W-1:0]               req_wdata_i,
    input  logic [DATA_W/8-1:0]             req_be_i,
    output logic                            ack_o,
    output logic                            err_o,
    output logic [DATA_W-1:0]               rdata_o,
    input  logic                            sdram_rd_i,
    output logic [BANK_AW-1:0]              ext_addr_o,
    output logic [DATA_W-1:0]               ext_wdata_o,
    input  logic [DATA_W-1:0]               ext_rdata_i,
    output logic [DATA_W/8-1:0]             ext_be_n_o,
    output logic [NUM_BANKS-1:0]            ext_cs_n_o,
    output logic                            ext_rd_n_o,
    output logic                            ext_wr_n_o,
    input  logic                            ext_hs_n_i,
    output logic                            ext_dir_n_o,
    output logic [1:0]                      ext_oe_n_o
);

    localparam int SEL_W   = $clog2(NUM_BANKS);
    localparam int WADDR_W = BANK_AW + SEL_W - 2;
    localparam int BE_W    = DATA_W / 8;
    localparam int LEN_W   = XB_WAIT_W + 2;

    bank_cfg_t              cfg_live, cfg_q;
    logic                   hit_live, ok_live;
    logic [NUM_BANKS-1:0]   sel_live, sel_q;
    logic [BANK_AW-3:0]     waddr_q;
    logic                   we_q, err_q;
    logic [DATA_W-1:0]      wdata_q;
    logic [BE_W-1:0]        be_q;
    xb_state_e              st;
    logic [1:0]             beat;
    logic                   beat_end, strb;
    logic [XB_WAIT_W-1:0]   waits_use;

    xbus_bank_dec #(
        .NUM_BANKS (NUM_BANKS),
        .SEL_W     (SEL_W),
        .BANK_PW   (BANK_PW),
        .BANK_WAITS(BANK_WAITS),
        .BANK_WP   (BANK_WP),
        .BANK_ACK  (BANK_ACK)
    ) u_dec (
        .sel_i   (req_waddr_i[WADDR_W-1 -: SEL_W]),
        .cfg_o   (cfg_live),
        .hit_o   (hit_live),
        .onehot_o(sel_live)
    );

    // Accept only mapped banks, and writes only to unprotected ones.
    always_comb begin
        ok_live   = hit_live && !(req_we_i && cfg_live.wp);
        waits_use = (st == ST_IDLE) ? cfg_live.waits : cfg_q.waits;
        strb      = (st == ST_STRB);
    end

    // Capture the request and its bank configuration on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            sel_q   <= '0;
            waddr_q <= '0;
            we_q    <= 1'b0;
            err_q   <= 1'b0;
            wdata_q <= '0;
            be_q    <= '0;
        end else if (st == ST_IDLE && req_i) begin
            cfg_q   <= cfg_live;
            sel_q   <= sel_live;
            waddr_q <= req_waddr_i[BANK_AW-3:0];
            we_q    <= req_we_i;
            err_q   <= !ok_live;
            wdata_q <= req_wdata_i;
            be_q    <= req_be_i;
        end
    end

    xbus_seq #(
        .WAIT_W(XB_WAIT_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req_i),
        .ok_i      (ok_live),
        .last_i    (last_beat(cfg_q.pw)),
        .waits_i   (waits_use),
        .ackm_i    (cfg_q.ackm),
        .hs_n_i    (ext_hs_n_i),
        .st_o      (st),
        .beat_o    (beat),
        .beat_end_o(beat_end)
    );

    xbus_rd_pack #(
        .DATA_W(DATA_W)
    ) u_pack (
        .clk   (clk),
        .rst_n (rst_n),
        .cap_i (beat_end && !we_q),
        .pw_i  (cfg_q.pw),
        .beat_i(beat),
        .bus_i (ext_rdata_i),
        .word_o(rdata_o)
    );

    // Beat address, write lanes and byte enables by port width.
    always_comb begin
        case (cfg_q.pw)
            PW_8: begin
                ext_addr_o  = {waddr_q, beat};
                ext_wdata_o = {{(DATA_W-8){1'b0}}, wdata_q[8*beat +: 8]};
                ext_be_n_o  = {{(BE_W-1){1'b1}}, ~be_q[beat]};
            end
            PW_16: begin
                ext_addr_o  = {waddr_q, beat[0], 1'b0};
                ext_wdata_o = {{(DATA_W-16){1'b0}}, wdata_q[16*beat[0] +: 16]};
                ext_be_n_o  = {{(BE_W-2){1'b1}}, ~be_q[2*beat[0] +: 2]};
            end
            default: begin
                ext_addr_o  = {waddr_q, 2'b00};
                ext_wdata_o = wdata_q;
                ext_be_n_o  = ~be_q;
            end
        endcase
        if (!we_q) ext_be_n_o = '0;
    end

    // Strobes, selects, transceiver controls and completion.
    always_comb begin
        ext_cs_n_o    = strb ? ~sel_q : '1;
        ext_rd_n_o    = ~(strb && !we_q);
        ext_wr_n_o    = ~(strb && we_q);
        ext_dir_n_o   = ~((strb && !we_q) || sdram_rd_i);
        ext_oe_n_o[0] = ~(strb && !we_q);
        ext_oe_n_o[1] = ~sdram_rd_i;
        ack_o         = (st == ST_DONE);
        err_o         = (st == ST_DONE) && err_q;
    end

    // ---------------------------------------------------------------
    // Checks. Strobe length counter feeds the minimum-width check.
    logic             strb_port;
    logic [LEN_W-1:0] strb_len;

    assign strb_port = !ext_rd_n_o || !ext_wr_n_o;

    // Count consecutive strobe cycles, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)         strb_len <= '0;
        else if (strb_port) strb_len <= (strb_len == '1) ? strb_len : strb_len + 1'b1;
        else                strb_len <= '0;
    end

    // R1: at most one bank select low at any time.
    p_one_select_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ext_cs_n_o));

    // R1: a select is low only inside a strobe.
    p_select_in_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_cs_n_o != '1) |-> strb_port);

    // R5: a strobe that ends lasted at least the wait count plus one.
    p_min_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(strb_port) |-> (strb_len >= ({2'b00, cfg_q.waits} + 1'b1)));

    // R8: address stays put through a strobe.
    p_addr_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_port && $past(strb_port)) |-> $stable(ext_addr_o));

    // R9: writes keep the direction high, reads pull it low.
    p_dir_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_wr_n_o |-> ext_dir_n_o);
    p_dir_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_rd_n_o |-> !ext_dir_n_o);

    // R10: the device-read enable is low only during a read strobe.
    p_oe_dev_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_oe_n_o[0] |-> !ext_rd_n_o);

    // R11: no write strobe ever reaches a protected bank.
    p_no_prot_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_wr_n_o |-> !cfg_q.wp);

    // R13: acknowledge is a single-cycle pulse, and error rides on it.
    p_ack_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o);
    p_err_with_ack_r13: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> ack_o);

endmodule

// File: tb/xbus_ctrl_tb.sv
// Bench for xbus_ctrl: directed corner cases and seeded random requests,
// with a behavioural bus responder and expected values from bench functions.
module xbus_ctrl_tb_top;

    localparam logic [11:0] CFG_PW  = 12'b01_00_10_10_01_00;
    localparam logic [23:0] CFG_WT  = 24'h2_1_2_0_1_3;
    localparam logic [5:0]  CFG_WP  = 6'b001000;
    localparam logic [5:0]  CFG_ACK = 6'b110000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, req_we = 1'b0;
    logic [26:0] req_waddr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_be = '0;
    logic        ack, err;
    logic [31:0] rdata;
    logic        sdram_rd = 1'b0;
    logic [25:0] ext_addr;
    logic [31:0] ext_wdata, ext_rdata;
    logic [3:0]  ext_be_n;
    logic [5:0]  ext_cs_n;
    logic        ext_rd_n, ext_wr_n, ext_dir_n;
    logic        ext_hs_n = 1'b1;
    logic [1:0]  ext_oe_n;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    always #4 clk = ~clk;

    xbus_ctrl #(
        .BANK_PW(CFG_PW), .BANK_WAITS(CFG_WT), .BANK_WP(CFG_WP), .BANK_ACK(CFG_ACK)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_i(req), .req_we_i(req_we), .req_waddr_i(req_waddr),
        .req_wdata_i(req_wdata), .req_be_i(req_be),
        .ack_o(ack), .err_o(err), .rdata_o(rdata),
        .sdram_rd_i(sdram_rd),
        .ext_addr_o(ext_addr), .ext_wdata_o(ext_wdata), .ext_rdata_i(ext_rdata),
        .ext_be_n_o(ext_be_n), .ext_cs_n_o(ext_cs_n),
        .ext_rd_n_o(ext_rd_n), .ext_wr_n_o(ext_wr_n), .ext_hs_n_i(ext_hs_n),
        .ext_dir_n_o(ext_dir_n), .ext_oe_n_o(ext_oe_n)
    );

    function automatic logic [31:0] dev_word(input logic [25:0] a);
        return ({6'b0, a} * 32'h0101_0193) ^ 32'hC3A5_5A3C;
    endfunction

    assign ext_rdata = dev_word(ext_addr);

    // Responder and beat log, updated at the falling edge.
    logic [25:0] b_addr [8];
    logic [31:0] b_wd   [8];
    logic [3:0]  b_ben  [8];
    logic [5:0]  b_cs   [8];
    logic        b_dir  [8];
    logic [1:0]  b_oe   [8];
    int nb_cap = 0, run = 0, resp_d = 0;

    always @(negedge clk) begin
        if (!ext_rd_n || !ext_wr_n) begin
            int bk;
            bk = 0;
            for (int i = 0; i < 6; i++) if (!ext_cs_n[i]) bk = i;
            if (run == 0 && nb_cap < 8) begin
                b_addr[nb_cap] = ext_addr;
                b_wd[nb_cap]   = ext_wdata;
                b_ben[nb_cap]  = ext_be_n;
                b_cs[nb_cap]   = ext_cs_n;
                b_dir[nb_cap]  = ext_dir_n;
                b_oe[nb_cap]   = ext_oe_n;
                nb_cap++;
            end
            if (CFG_ACK[bk]) ext_hs_n = !(run >= resp_d);
            else             ext_hs_n = (run >= resp_d);
            run++;
        end else begin
            run = 0;
            ext_hs_n = 1'b1;
        end
    end

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    function automatic int beats_of(input int bk);
        case (CFG_PW[2*bk +: 2])
            2'd0:    return 4;
            2'd1:    return 2;
            default: return 1;
        endcase
    endfunction

    // One request, checked against values computed from the requirements.
    task automatic run_req(input logic we, input int bk, input logic [23:0] wa,
                           input logic [31:0] wd, input logic [3:0] be, input int d);
        int k, nb, w, lat, pw;
        bit got, exp_err;
        logic [25:0] base;
        logic [31:0] got_rd, exp_rd, ew, dw;
        logic [3:0]  eb;
        logic        got_err;
        nb_cap = 0;
        resp_d = d;
        base = {wa, 2'b00};
        @(negedge clk);
        req = 1'b1; req_we = we; req_waddr = {3'(bk), wa}; req_wdata = wd; req_be = be;
        k = 0; got = 0;
        while (k < 400 && !got) begin
            @(posedge clk); #1; k++;
            if (ack) got = 1;
        end
        got_rd = rdata; got_err = err;
        @(negedge clk);
        req = 1'b0;
        exp_err = (bk >= 6) || (we && CFG_WP[bk]);
        chk(got, "R13 ack seen", 32'(got), 1);
        chk(got_err == exp_err, exp_err ? "R11/R12 err flag" : "R13 err clear", 32'(got_err), 32'(exp_err));
        if (exp_err) begin
            chk(k == 1, "R12 error ack latency (also R11)", k, 1);
            chk(nb_cap == 0, "R11 no strobe on refused access", nb_cap, 0);
        end else begin
            nb = beats_of(bk);
            pw = int'(CFG_PW[2*bk +: 2]);
            w  = int'(CFG_WT[4*bk +: 4]);
            lat = nb * (((w > d) ? w : d) + 2) + 1;
            // R5, R6, R7, R8 shape every beat's length.
            chk(k == lat, "R13 latency (R5 R6 R7 R8)", k, lat);
            chk(nb_cap == nb, "R2 beat count", nb_cap, nb);
            exp_rd = '0;
            for (int b = 0; b < nb && b < 8; b++) begin
                logic [25:0] ea;
                ea = (pw == 0) ? base + 26'(b) : (pw == 1) ? base + 26'(2*b) : base;
                chk(b_addr[b] == ea, "R2 beat address", 32'(b_addr[b]), 32'(ea));
                chk(b_cs[b] == ~(6'b1 << bk), "R1 bank select", 32'(b_cs[b]), 32'(~(6'b1 << bk)));
                if (we) begin
                    if (pw == 0) begin ew = {24'h0, wd[8*b +: 8]};   eb = {3'b111, ~be[b]}; end
                    else if (pw == 1) begin ew = {16'h0, wd[16*b +: 16]}; eb = {2'b11, ~be[2*b +: 2]}; end
                    else begin ew = wd; eb = ~be; end
                    chk(b_wd[b] == ew, "R3 write lanes", b_wd[b], ew);
                    chk(b_ben[b] == eb, "R3 write byte enables", 32'(b_ben[b]), 32'(eb));
                    chk(b_dir[b] == 1'b1, "R9 dir high on write", 32'(b_dir[b]), 1);
                    chk(b_oe[b] == 2'b11, "R10 enables off on write", 32'(b_oe[b]), 3);
                end else begin
                    dw = dev_word(ea);
                    if (pw == 0) exp_rd[8*b +: 8] = dw[7:0];
                    else if (pw == 1) exp_rd[16*b +: 16] = dw[15:0];
                    else exp_rd = dw;
                    chk(b_ben[b] == 4'h0, "R3 read lanes all enabled", 32'(b_ben[b]), 0);
                    chk(b_dir[b] == 1'b0, "R9 dir low on read", 32'(b_dir[b]), 0);
                    chk(b_oe[b] == 2'b10, "R10 device read enable", 32'(b_oe[b]), 2);
                end
            end
            if (!we) chk(got_rd == exp_rd, "R4 assembled read data", got_rd, exp_rd);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R14 reset state
        chk(ext_cs_n == 6'h3F, "R14 selects idle", 32'(ext_cs_n), 32'h3F);
        chk({ext_rd_n, ext_wr_n} == 2'b11, "R14 strobes idle", 32'({ext_rd_n, ext_wr_n}), 3);
        chk(ext_oe_n == 2'b11 && ext_dir_n, "R14 transceiver idle", 32'({ext_dir_n, ext_oe_n}), 7);
        chk(!ack, "R14 no ack", 32'(ack), 0);

        // R10 and R9: SDRAM read indication alone
        sdram_rd = 1'b1; #1;
        chk(ext_oe_n == 2'b01, "R10 SDRAM read enable", 32'(ext_oe_n), 1);
        chk(ext_dir_n == 1'b0, "R9 dir low on SDRAM read", 32'(ext_dir_n), 0);
        @(negedge clk); sdram_rd = 1'b0; #1;
        chk(ext_oe_n == 2'b11 && ext_dir_n, "R10 SDRAM enable released", 32'({ext_dir_n, ext_oe_n}), 7);

        // Directed: each width, write then read
        run_req(1'b1, 0, 24'h000010, 32'hA1B2C3D4, 4'b1011, 0);  // 8-bit boot bank
        run_req(1'b0, 0, 24'h000010, 32'h0, 4'h0, 0);
        run_req(1'b1, 1, 24'h123456, 32'h11223344, 4'b0110, 0);  // 16-bit
        run_req(1'b0, 1, 24'h123456, 32'h0, 4'h0, 0);
        run_req(1'b1, 2, 24'hFFFFFF, 32'hDEADBEEF, 4'b1111, 0);  // 32-bit, top of bank
        run_req(1'b0, 2, 24'h000000, 32'h0, 4'h0, 0);
        // R6 wait extension beyond the wait count
        run_req(1'b0, 1, 24'h000100, 32'h0, 4'h0, 6);
        run_req(1'b1, 2, 24'h000200, 32'h55AA55AA, 4'b0101, 3);
        // R7 acknowledge mode, immediate and late
        run_req(1'b0, 4, 24'h000300, 32'h0, 4'h0, 0);
        run_req(1'b1, 4, 24'h000301, 32'h0F1E2D3C, 4'b1111, 5);
        run_req(1'b0, 5, 24'h000400, 32'h0, 4'h0, 4);
        // R11 protected bank: write refused, read allowed
        run_req(1'b1, 3, 24'h000500, 32'hCAFEF00D, 4'b1111, 0);
        run_req(1'b0, 3, 24'h000500, 32'h0, 4'h0, 0);
        // R12 unmapped bank indices
        run_req(1'b0, 6, 24'h000001, 32'h0, 4'h0, 0);
        run_req(1'b1, 7, 24'h000002, 32'h12345678, 4'b1111, 0);

        // Seeded random mix
        for (int t = 0; t < 60; t++) begin
            run_req(1'($urandom_range(0, 1)), int'($urandom_range(0, 7)),
                    24'($urandom), $urandom, 4'($urandom), int'($urandom_range(0, 6)));
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired before the run completed");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule